// File: doc/BRIEF.md
# Sparse Minor-Opcode Decoder

This unit decodes the instructions of a single major opcode (value 19 in bits 31..26) of a 32-bit RISC instruction set. That major opcode has a 10-bit minor opcode field in which only a few encodings are used. The decode is split into two separate lookups. A 1024-entry, one-bit legality bitmap is indexed by the whole minor field. A separate 8-entry operation table is indexed by only three instruction bits. Because of this, every legal instruction in one column of the opcode map shares a single decode entry. The condition-register field move and all condition-register logical operations therefore come out as one group. The three branch-through-register forms (to link, to count and to target register) also come out as one group. A later stage tells those forms apart by looking at instruction bits 10 and 6.

An outer decoder places the instruction word and a valid flag on the inputs. It reads back three things: an illegal flag, a 3-bit operation code, and a few control attributes. When the major opcode is not 19, the unit raises a not-mine flag and leaves the illegal flag clear, so the outer decoder can handle the word itself. A parameter selects one of two variants: registered outputs with one cycle of latency, or a purely combinational path.

Top module: `minor_op_decoder`

## Requirements
- R1: The minor opcode is instruction bits 10..1. For a valid word with major opcode 19, the illegal flag is 1 exactly when that minor value is not one of 0, 16, 18, 33, 129, 150, 193, 225, 257, 289, 417, 449, 528 or 560.
- R2: For a legal minor opcode, the operation code comes from the index {bit 5, bit 3, bit 2}. Index 000 gives 2 (condition-register group). Index 100 gives 3 (branch through register). Index 101 gives 4 (return from interrupt). Index 111 gives 5 (instruction synchronize).
- R3: A minor opcode missing from the bitmap produces operation code 1 (illegal) with the illegal flag set. This holds even when its index selects an occupied column.
- R4: Minor opcodes 16, 528 and 560 all produce the same operation code 3. Instruction bits 10 and 6 have no effect on it.
- R5: The writes-condition-register attribute is 1 only for code 2. The register-branch attribute is 1 only for code 3. The serialize attribute is 1 only for codes 4 and 5.
- R6: When the valid input is 0, every output is 0: operation code 0 (no-op), illegal 0, not-mine 0, all attributes 0.
- R7: For a valid word whose bits 31..26 are not 19, not-mine is 1, illegal is 0, the operation code is 0 and all attributes are 0.
- R8: With REG_OUT=1, each output reflects the input sampled at the previous rising clock edge. An active-low reset forces all outputs to 0.
- R9: Instruction bits 25..11 and bit 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset of the output register |
| in_valid | input | 1 | Instruction word is present |
| in_instr | input | 32 | Instruction word |
| dec_illegal | output | 1 | Minor opcode is not legal |
| dec_not_mine | output | 1 | Major opcode belongs to another decoder |
| dec_op | output | 3 | Internal operation code |
| dec_writes_cr | output | 1 | Operation writes the condition register |
| dec_reg_branch | output | 1 | Branch whose target comes from a register |
| dec_serialize | output | 1 | Operation needs context synchronization |

## Verification
The bench sweeps all 1024 minor opcodes with the major opcode fixed at 19. This separates bitmap gaps from legal entries, and it exposes any column that maps to the wrong group, including illegal encodings whose column is occupied. A table of directed words covers several cases: the three branch forms, with differing bits 10 and 6, must give one code; filler ones in the ignored bits must change nothing; a foreign major opcode must raise not-mine; a low valid flag must force a no-op. Directed steps then check that the output stays unchanged until the next edge after an input change, and that a reset issued mid-run clears a legal decode.

// File: rtl/minor_op_decoder.sv
module minor_op_decoder #(
  parameter bit          REG_OUT    = 1'b1,
  parameter int          INSN_W     = 32,
  parameter int          MINOR_W    = 10,
  parameter int          OP_W       = 3,
  parameter logic [5:0]  MAJOR_CODE = 6'd19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_instr,
  output logic              dec_illegal,
  output logic              dec_not_mine,
  output logic [OP_W-1:0]   dec_op,
  output logic              dec_writes_cr,
  output logic              dec_reg_branch,
  output logic              dec_serialize
);

  localparam int MAP_N = 1 << MINOR_W;

  localparam logic [OP_W-1:0] OP_NOP   = OP_W'(0);
  localparam logic [OP_W-1:0] OP_ILL   = OP_W'(1);
  localparam logic [OP_W-1:0] OP_CRGRP = OP_W'(2);
  localparam logic [OP_W-1:0] OP_BREG  = OP_W'(3);
  localparam logic [OP_W-1:0] OP_RFI   = OP_W'(4);
  localparam logic [OP_W-1:0] OP_ISYNC = OP_W'(5);

  function automatic logic is_member(input int m);
    case (m)
      0, 16, 18, 33, 129, 150, 193, 225,
      257, 289, 417, 449, 528, 560: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic [MAP_N-1:0] build_map();
    logic [MAP_N-1:0] m;
    for (int i = 0; i < MAP_N; i++) m[i] = is_member(i);
    return m;
  endfunction

  localparam logic [MAP_N-1:0] LEGAL_MAP = build_map();

  localparam logic [OP_W-1:0] COL_TABLE [8] = '{
    OP_CRGRP, OP_ILL, OP_ILL, OP_ILL,
    OP_BREG,  OP_RFI, OP_ILL, OP_ISYNC
  };

  logic [MINOR_W-1:0] minor;
  logic [2:0]         col;
  logic               mine;
  logic               bit_ok;
  logic [OP_W-1:0]    col_op;

  assign minor  = in_instr[MINOR_W:1];
  assign col    = {in_instr[5], in_instr[3], in_instr[2]};
  assign mine   = in_instr[INSN_W-1 -: 6] == MAJOR_CODE;
  assign bit_ok = LEGAL_MAP[minor];
  assign col_op = COL_TABLE[col];

  logic            n_ill, n_nm, n_wcr, n_rb, n_ser;
  logic [OP_W-1:0] n_op;

  always_comb begin
    n_ill = 1'b0;
    n_nm  = 1'b0;
    n_op  = OP_NOP;
    if (in_valid) begin
      if (!mine) begin
        n_nm = 1'b1;
      end else if (!bit_ok || col_op == OP_ILL) begin
        n_ill = 1'b1;
        n_op  = OP_ILL;
      end else begin
        n_op  = col_op;
      end
    end
  end

  assign n_wcr = n_op == OP_CRGRP;
  assign n_rb  = n_op == OP_BREG;
  assign n_ser = (n_op == OP_RFI) || (n_op == OP_ISYNC);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dec_illegal    <= 1'b0;
          dec_not_mine   <= 1'b0;
          dec_op         <= OP_NOP;
          dec_writes_cr  <= 1'b0;
          dec_reg_branch <= 1'b0;
          dec_serialize  <= 1'b0;
        end else begin
          dec_illegal    <= n_ill;
          dec_not_mine   <= n_nm;
          dec_op         <= n_op;
          dec_writes_cr  <= n_wcr;
          dec_reg_branch <= n_rb;
          dec_serialize  <= n_ser;
        end
      end

      AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (dec_op == OP_NOP && !dec_illegal && !dec_not_mine)); // R6
      AST_FOREIGN_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(in_instr[INSN_W-1 -: 6]) != MAJOR_CODE) |-> dec_not_mine); // R7
      AST_SPARSE_FILLER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid) && $past(mine) && !$past(bit_ok)) |-> (dec_illegal && dec_op == OP_ILL)); // R3
    end else begin : g_comb
      assign dec_illegal    = n_ill;
      assign dec_not_mine   = n_nm;
      assign dec_op         = n_op;
      assign dec_writes_cr  = n_wcr;
      assign dec_reg_branch = n_rb;
      assign dec_serialize  = n_ser;
    end
  endgenerate

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_illegal && dec_not_mine)); // R7
  AST_ILL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_illegal |-> dec_op == OP_ILL); // R3
  AST_ATTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_writes_cr, dec_reg_branch, dec_serialize})); // R5
  AST_NOT_MINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dec_not_mine |-> (dec_op == OP_NOP && !dec_writes_cr && !dec_reg_branch && !dec_serialize)); // R7

endmodule

// File: tb/minor_op_decoder_tb.sv
module minor_op_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic        dec_illegal, dec_not_mine, dec_writes_cr, dec_reg_branch, dec_serialize;
  logic [2:0]  dec_op;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  minor_op_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .dec_illegal(dec_illegal), .dec_not_mine(dec_not_mine), .dec_op(dec_op),
    .dec_writes_cr(dec_writes_cr), .dec_reg_branch(dec_reg_branch),
    .dec_serialize(dec_serialize)
  );

  // {valid, instr, illegal, not_mine, op, {wcr, rb, ser}}
  localparam int NV = 10;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, {6'd19, 15'd0,     10'd0,   1'b0}, 1'b0, 1'b0, 3'd2, 3'b100}, // R2 R5
    {1'b1, {6'd19, 15'd0,     10'd16,  1'b0}, 1'b0, 1'b0, 3'd3, 3'b010}, // R2 R4
    {1'b1, {6'd19, 15'h7fff,  10'd528, 1'b1}, 1'b0, 1'b0, 3'd3, 3'b010}, // R4 R9
    {1'b1, {6'd19, 15'h1234,  10'd560, 1'b0}, 1'b0, 1'b0, 3'd3, 3'b010}, // R4 R9
    {1'b1, {6'd19, 15'd0,     10'd18,  1'b0}, 1'b0, 1'b0, 3'd4, 3'b001}, // R2 R5
    {1'b1, {6'd19, 15'h5555,  10'd150, 1'b1}, 1'b0, 1'b0, 3'd5, 3'b001}, // R2 R9
    {1'b1, {6'd19, 15'd0,     10'd1,   1'b0}, 1'b1, 1'b0, 3'd1, 3'b000}, // R3
    {1'b1, {6'd19, 15'd0,     10'd20,  1'b0}, 1'b1, 1'b0, 3'd1, 3'b000}, // R1
    {1'b1, {6'd31, 15'd0,     10'd16,  1'b0}, 1'b0, 1'b1, 3'd0, 3'b000}, // R7
    {1'b0, {6'd19, 15'd0,     10'd16,  1'b0}, 1'b0, 1'b0, 3'd0, 3'b000}  // R6
  };

  function automatic bit exp_legal(input int m);
    case (m)
      0, 16, 18, 33, 129, 150, 193, 225,
      257, 289, 417, 449, 528, 560: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] exp_col_op(input logic [9:0] m);
    case ({m[4], m[2], m[1]})
      3'b000:  return 3'd2;
      3'b100:  return 3'd3;
      3'b101:  return 3'd4;
      3'b111:  return 3'd5;
      default: return 3'd1;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] outs();
    return {dec_illegal, dec_not_mine, dec_op, dec_writes_cr, dec_reg_branch, dec_serialize, 1'b0};
  endfunction

  task automatic drive(input logic v, input logic [31:0] w);
    @(negedge clk);
    in_valid = v;
    in_instr = w;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "reset outputs", outs(), 9'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][40], VEC[i][39:8]);
      check("R2", $sformatf("vector %0d", i), outs(), {VEC[i][7:0], 1'b0});
    end

    for (int m = 0; m < 1024; m++) begin
      logic [9:0] mm;
      logic [2:0] eop;
      mm = 10'(m);
      eop = exp_legal(m) ? exp_col_op(mm) : 3'd1;
      drive(1'b1, {6'd19, 15'h2aaa, mm, 1'b1});
      check("R1", $sformatf("illegal flag minor %0d", m), {8'd0, dec_illegal}, {8'd0, (eop == 3'd1)});
      check("R3", $sformatf("op code minor %0d", m), {6'd0, dec_op}, {6'd0, eop});
    end

    // R8: output holds until the next rising edge
    drive(1'b0, 32'd0);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = {6'd19, 15'd0, 10'd16, 1'b0};
    #1;
    check("R8", "before edge", {6'd0, dec_op}, 9'd0);
    @(negedge clk);
    check("R8", "after edge", {6'd0, dec_op}, 9'd3);

    // R8: reset mid-run clears a legal decode
    #1 rst_n = 1'b0;
    #1;
    check("R8", "reset mid-run", outs(), 9'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "after release", {6'd0, dec_op}, 9'd3);

    // R6: dropping valid with a legal word still present gives no-op
    drive(1'b0, {6'd19, 15'd0, 10'd0, 1'b0});
    check("R6", "valid low", outs(), 9'd0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule